// File: doc/BRIEF.md
# System Configuration and Register-Window Decoder

This block keeps the system configuration word of a microcontroller and decides whether a bus cycle falls inside the 4-Kbyte window that holds every on-chip control register. The CPU issues 20-bit addresses. The block widens them to a 24-bit bus address by copying bit 19 into bits 23:20, unless an external master drives those upper bits itself. A placement bit chooses where the window sits. When the bit is 1, the window base is 0xFFF000. When the bit is 0, the base is 0x7FF000. The placement bit may be written a single time after reset. If software clears it, the CPU can no longer reach the window, and this lasts until the next reset.

The configuration word also carries three pad-disable controls, used when the part runs without an external bus: one for the two instruction-tracking pins, one for the low three address pins and one for the read/write strobe pin. These controls are turned into active-high output enables for the pad ring. At reset their value is taken from the active-low bus-error pin. A low level selects single-chip operation and sets all three controls, and a high level clears them. Unlike the placement bit, these three controls can be rewritten at any time.

Top module: `sys_cfg_decode`

## Requirements
- R1: `blk_sel` is 1 exactly when `bus_addr[23:12]` equals {placement bit, 11'h7FF}.
- R2: `bus_addr[19:0]` equals `cpu_addr`. `bus_addr[23:20]` equals four copies of `cpu_addr[19]` when `ext_hi_drive` is 0, and equals `ext_hi_addr` when it is 1.
- R3: After reset the placement bit is 1. It reads back in bit 15 of the configuration word.
- R4: Only the first configuration write after reset changes the placement bit to `wdata[15]`. Every later configuration write leaves it unchanged, whatever value it carries.
- R5: While the placement bit is 0 and `ext_hi_drive` is 0, `blk_sel` stays 0 for every `cpu_addr`.
- R6: After reset, the three pad-disable controls (word bits 14, 13, 12) are all 1 if `berr_n` was low on the last reset clock, and all 0 if it was high.
- R7: `trk_oe` is 0 exactly when the tracking-disable control (bit 14) is 1 and `freeze` is 0. Otherwise it is 1.
- R8: `addr_lo_oe` is the inverse of the address-disable control (bit 13), and `rw_oe` is the inverse of the strobe-disable control (bit 12).
- R9: Every configuration write loads bits 14:12 from `wdata[14:12]`. A configuration read returns {placement, bit 14, bit 13, bit 12, 12'h000}. `rdata` is 0 in every cycle that is not a configuration read.
- R10: The configuration word answers only at window offset `CFG_OFS` (compared on `bus_addr[11:1]`, default offset 0x000). A write to any other offset inside the window leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| berr_n | input | 1 | Bus-error pin, active low, sampled while reset is held |
| freeze | input | 1 | Debug freeze indication |
| cpu_addr | input | 20 | Address issued by the CPU |
| ext_hi_drive | input | 1 | An external master drives address bits 23:20 |
| ext_hi_addr | input | 4 | Externally driven value of address bits 23:20 |
| bus_valid | input | 1 | Bus cycle active |
| bus_write | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data |
| bus_addr | output | 24 | Widened bus address |
| blk_sel | output | 1 | Register-window select |
| rdata | output | 16 | Configuration word read data |
| trk_oe | output | 1 | Output enable for the instruction-tracking pins |
| addr_lo_oe | output | 1 | Output enable for address pins 2:0 |
| rw_oe | output | 1 | Output enable for the read/write strobe pin |

## Verification
The assertions assume that reset is held for at least two clocks, so that the sampled bus-error level and the write-once flag hold defined values before any property is evaluated. They also assume that the bus inputs are steady around each rising edge. The stimulus changes inputs only on falling edges and holds reset for four clocks in each reset phase. After the placement bit has been cleared, the window is reached again only through the external upper-address drive. This exercises the ignored-write path without breaking the assumption that the CPU cannot reach the window.

// File: rtl/sys_cfg_decode.sv
module sys_cfg_decode #(
  parameter int          DATA_W  = 16,
  parameter logic [11:0] CFG_OFS = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              berr_n,
  input  logic              freeze,
  input  logic [19:0]       cpu_addr,
  input  logic              ext_hi_drive,
  input  logic [3:0]        ext_hi_addr,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] wdata,
  output logic [23:0]       bus_addr,
  output logic              blk_sel,
  output logic [DATA_W-1:0] rdata,
  output logic              trk_oe,
  output logic              addr_lo_oe,
  output logic              rw_oe
);
  localparam logic [10:0] WIN_TAG = 11'h7FF;
  localparam int          MAP_B   = DATA_W - 1;
  localparam int          TRK_B   = DATA_W - 2;
  localparam int          ALO_B   = DATA_W - 3;
  localparam int          RW_B    = DATA_W - 4;

  logic       map_q;
  logic       written_q;
  logic       berr_smp_q;
  logic [2:0] dis_q;
  logic       ofs_hit;
  logic       cfg_wr;
  logic       cfg_rd;

  assign bus_addr[19:0]  = cpu_addr;
  assign bus_addr[23:20] = ext_hi_drive ? ext_hi_addr : {4{cpu_addr[19]}};

  assign blk_sel = (bus_addr[23:12] == {map_q, WIN_TAG});
  assign ofs_hit = (bus_addr[11:1] == CFG_OFS[11:1]);
  assign cfg_wr  = bus_valid &  bus_write & blk_sel & ofs_hit;
  assign cfg_rd  = bus_valid & ~bus_write & blk_sel & ofs_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q      <= 1'b1;
      written_q  <= 1'b0;
      berr_smp_q <= berr_n;
      dis_q      <= {3{~berr_n}};
    end else if (cfg_wr) begin
      written_q <= 1'b1;
      dis_q     <= wdata[TRK_B:RW_B];
      if (!written_q) map_q <= wdata[MAP_B];
    end
  end

  always_comb begin
    rdata = '0;
    if (cfg_rd) begin
      rdata[MAP_B]      = map_q;
      rdata[TRK_B:RW_B] = dis_q;
    end
  end

  assign trk_oe     = ~(dis_q[2] & ~freeze);
  assign addr_lo_oe = ~dis_q[1];
  assign rw_oe      = ~dis_q[0];

  // R4
  map_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> map_q == $past(map_q));

  // R4
  written_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> written_q);

  // R1
  sel_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_sel |-> bus_addr[23] == map_q);

  // R5
  hidden_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_q && !ext_hi_drive) |-> !blk_sel);

  // R7
  trk_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_oe |-> !freeze);

  // R8
  rw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> rw_oe == !$past(wdata[RW_B]));

  // R6
  dis_reset_chk: assert property (@(posedge clk)
    (!rst_n && !berr_smp_q && $past(!rst_n)) |-> dis_q == 3'b111);
endmodule

// File: tb/sys_cfg_decode_bench.sv
module sys_cfg_decode_bench;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        berr_n = 1'b0;
  logic        freeze = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic        ext_hi_drive = 1'b0;
  logic [3:0]  ext_hi_addr = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] wdata = '0;
  logic [23:0] bus_addr;
  logic        blk_sel;
  logic [15:0] rdata;
  logic        trk_oe, addr_lo_oe, rw_oe;

  int checks = 0;
  int fails = 0;

  sys_cfg_decode u_sys_cfg_decode (
    .clk(clk), .rst_n(rst_n), .berr_n(berr_n), .freeze(freeze),
    .cpu_addr(cpu_addr), .ext_hi_drive(ext_hi_drive), .ext_hi_addr(ext_hi_addr),
    .bus_valid(bus_valid), .bus_write(bus_write), .wdata(wdata),
    .bus_addr(bus_addr), .blk_sel(blk_sel), .rdata(rdata),
    .trk_oe(trk_oe), .addr_lo_oe(addr_lo_oe), .rw_oe(rw_oe));

  always #(PER/2) clk = ~clk;

  bit       m_map = 1'b1;
  bit       m_once = 1'b0;
  bit [2:0] m_dis = 3'b000;

  function automatic logic [23:0] m_addr();
    return {(ext_hi_drive ? ext_hi_addr : {4{cpu_addr[19]}}), cpu_addr};
  endfunction
  function automatic bit m_sel();
    logic [23:0] a = m_addr();
    return a[23:12] == {m_map, 11'h7FF};
  endfunction
  function automatic bit m_hit();
    logic [23:0] a = m_addr();
    return m_sel() && bus_valid && a[11:1] == 11'h000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_map  = 1'b1;
      m_once = 1'b0;
      m_dis  = berr_n ? 3'b000 : 3'b111;
    end else if (m_hit() && bus_write) begin
      if (!m_once) m_map = wdata[15];
      m_once = 1'b1;
      m_dis  = wdata[14:12];
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic [15:0] er;
    er = (m_hit() && !bus_write) ? {m_map, m_dis, 12'h000} : 16'h0000;
    chk("R2 bus_addr", bus_addr, m_addr());
    chk("R1 blk_sel", {23'b0, blk_sel}, {23'b0, m_sel()});
    chk("R9 rdata", {8'b0, rdata}, {8'b0, er});
    chk("R7 trk_oe", {23'b0, trk_oe}, {23'b0, !(m_dis[2] && !freeze)});
    chk("R8 addr_lo_oe", {23'b0, addr_lo_oe}, {23'b0, !m_dis[1]});
    chk("R8 rw_oe", {23'b0, rw_oe}, {23'b0, !m_dis[0]});
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
    cmp_all();
  endtask

  task automatic bus(input logic v, input logic w, input logic [19:0] a, input logic [15:0] d);
    bus_valid = v; bus_write = w; cpu_addr = a; wdata = d;
    cyc();
  endtask

  task automatic do_reset(input logic b);
    rst_n = 1'b0; berr_n = b;
    bus_valid = 1'b0;
    repeat (4) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  initial begin
    #(PER * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R3 R6 reset word single-chip", {8'b0, rdata}, 24'h00F000);
    freeze = 1'b1; cyc();
    chk("R7 freeze enables tracking", {23'b0, trk_oe}, 24'h1);
    freeze = 1'b0; cyc();
    chk("R7 no freeze disables tracking", {23'b0, trk_oe}, 24'h0);

    bus(1, 1, 20'hFF000, 16'h8000);
    bus(1, 0, 20'hFF001, 16'h0);
    chk("R9 first write read", {8'b0, rdata}, 24'h008000);
    bus(1, 1, 20'hFF000, 16'h0000);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R4 second write keeps placement", {8'b0, rdata}, 24'h008000);
    bus(1, 1, 20'hFF000, 16'h7000);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R9 disables rewritable", {8'b0, rdata}, 24'h00F000);
    bus(1, 1, 20'hFF002, 16'h0000);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R10 other offset ignored", {8'b0, rdata}, 24'h00F000);
    bus(0, 0, 20'hFF000, 16'h0);
    chk("R9 idle rdata zero", {8'b0, rdata}, 24'h0);

    for (int i = 0; i < 300; i++) begin
      ext_hi_drive = $urandom_range(0, 1);
      ext_hi_addr  = 4'($urandom);
      freeze       = 1'($urandom);
      bus(1'($urandom), 1'b0, (i % 3 == 0) ? 20'hFF000 | 20'($urandom_range(0, 4095)) : 20'($urandom), 16'h0);
    end
    ext_hi_drive = 1'b0;

    do_reset(1'b1);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R6 reset word with bus error high", {8'b0, rdata}, 24'h008000);
    chk("R8 pins enabled", {22'b0, addr_lo_oe, rw_oe}, 24'h3);
    bus(1, 1, 20'hFF000, 16'h1000);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R4 first write clears placement", {23'b0, blk_sel}, 24'h0);
    chk("R8 rw disabled", {23'b0, rw_oe}, 24'h0);
    for (int i = 0; i < 200; i++) begin
      bus(1'($urandom), 1'($urandom), 20'($urandom), 16'($urandom));
      chk("R5 window hidden", {23'b0, blk_sel}, 24'h0);
    end
    ext_hi_drive = 1'b1; ext_hi_addr = 4'h7;
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R1 external reach", {8'b0, rdata}, 24'h001000);
    bus(1, 1, 20'hFF000, 16'hE000);
    bus(1, 0, 20'hFF000, 16'h0);
    chk("R4 later write ignored", {8'b0, rdata}, 24'h006000);
    ext_hi_drive = 1'b0;
    bus(0, 0, 20'h00000, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule